// File: doc/BRIEF.md
# Capture/Compare Channel with Preloaded Compare Value

This block is one 16-bit timer channel that sits next to a free-running up-counter. It runs in one of two modes. In output-compare mode it holds a compare value and drives its output pin high for as long as the counter equals that value. Software writes that value through a small register port. The value passes through a preload (shadow) register, which is copied into the active register either at once or only on an update strobe, as chosen by a control bit. In input-capture mode the same active register instead records the counter value whenever a selected input rises.

The capture input is chosen from five candidate signals by a 4-bit selector. The chosen signal is resynchronised and then edge-detected. Each capture sets a sticky flag, and each compare match sets another. Software clears either flag by writing a one to it.

The register port has four word addresses:
- Address 0 (control): bit 0 is the mode, 0 = output compare and 1 = input capture. Bit 1 is the preload enable.
- Address 1: the value register.
- Address 2: the source selector in bits 3:0.
- Address 3: flags. Bit 0 is the compare flag and bit 1 is the capture flag.

Read data is registered. It appears on `rd_data_o` in the cycle after the clock edge that sampled `rd_en_i`.

Top module: `ccp_channel`

## Requirements
- R1: A synchronous active-low reset clears the mode, preload enable, selector, preload value, active value, both flags and the read data to zero.
- R2: In output mode with preload disabled, a write to address 1 loads both the preload register and the active compare register on the same clock edge.
- R3: In output mode with preload enabled, a write to address 1 loads only the preload register. The active register takes the preload value only on an edge where `upd_i` is high.
- R4: `ch_out_o` is high exactly when the channel is in output mode and `cnt_i` equals the active compare value. In input mode it is always low.
- R5: A compare match sets bit 0 of address 3 on the next edge. The bit stays set until a write to address 3 with bit 0 = 1 clears it.
- R6: In input mode, a rising edge of the selected source is captured two edges after it is first sampled. The active register then takes `cnt_i`, and reading address 1 in input mode returns that captured value.
- R7: Selector code 0 picks `src_i[0]` (the pin), and codes 1 to 4 pick `src_i[1]` to `src_i[4]`. Every other code feeds a constant low, so no capture can occur. A source that is not selected has no effect.
- R8: Reading address 2 returns the 4-bit selector in bits 3:0, with bits 15:4 always zero whatever was written.
- R9: In input mode, writes to address 1 are ignored. Neither the preload nor the active value changes.
- R10: A read of address 1 issued in the cycle in which a capture takes effect returns the newly captured counter value.
- R11: Each capture sets bit 1 of address 3, also visible on `cap_flag_o`. The bit stays set until a write to address 3 with bit 1 = 1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_i | input | 16 | Current counter value |
| upd_i | input | 1 | Update-event strobe, one cycle |
| src_i | input | 5 | Candidate capture inputs; bit 0 is the channel pin |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register word address |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Registered read data |
| ch_out_o | output | 1 | Compare output |
| cmp_flag_o | output | 1 | Sticky compare flag |
| cap_flag_o | output | 1 | Sticky capture flag |

## Verification
The bound checker watches several rules on every cycle:
- the direct load of the compare value when preload is off;
- that the active value holds between update strobes when preload is on;
- that writes are ignored in capture mode;
- that the selector's upper read bits stay zero;
- that the output stays silent in capture mode and every match is followed by the compare flag.

Other behaviours can only be shown by the bench's scenarios. These are the synchroniser latency of a capture, which source each selector code actually routes, the reserved codes never capturing, and the bypass that makes a read coinciding with a capture return the fresh count.

// File: rtl/ccp_pkg.sv
// Package: shared constants and types of the capture/compare channel.
// Assumes a two-bit word address space for the register port.
package ccp_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_VAL  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_SEL  = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_FLAG = 2'd3;

    // Bit positions inside the control and flag words
    localparam int CTRL_MODE_BIT = 0;
    localparam int CTRL_PE_BIT   = 1;
    localparam int FLAG_CMP_BIT  = 0;
    localparam int FLAG_CAP_BIT  = 1;

    typedef enum logic {
        MODE_COMPARE = 1'b0,
        MODE_CAPTURE = 1'b1
    } ch_mode_e;
endpackage

// File: rtl/ccp_capture.sv
// Module: ccp_capture
// Selects one of N_SRC candidate inputs by code, resynchronises it and emits
// a one-cycle pulse on each rising edge. Codes at or above N_SRC select a
// constant low. Assumes inputs may be asynchronous to clk.
module ccp_capture #(
    parameter int N_SRC       = 5,
    parameter int SEL_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             rise_o
);
    logic                   muxed;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Pick the selected source; reserved codes give constant low
    always_comb begin
        muxed = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel_i == SEL_W'(i)) muxed = src_i[i];
        end
    end

    // Synchroniser chain feeding the edge register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], muxed};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Rising edge of the synchronised input
    assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/ccp_compare.sv
// Module: ccp_compare
// Equality comparator between counter and active compare value; gates the
// channel output by the mode. Assumes both operands are in the clk domain.
module ccp_compare #(
    parameter int DATA_W = 16
) (
    input  logic              capture_mode_i,
    input  logic [DATA_W-1:0] cnt_i,
    input  logic [DATA_W-1:0] active_i,
    output logic              match_o
);
    // Match only counts in output-compare mode
    always_comb match_o = !capture_mode_i && (cnt_i == active_i);
endmodule

// File: rtl/ccp_regs.sv
// Module: ccp_regs
// Register file of the channel: control, preload and active value, source
// selector, sticky flags and registered read data. Assumes cap_evt_i is a
// single-cycle pulse already qualified by nothing but the edge detector.
module ccp_regs
    import ccp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cnt_i,
    input  logic              upd_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rise_i,
    input  logic              match_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              mode_o,
    output logic              pe_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [DATA_W-1:0] preload_o,
    output logic [DATA_W-1:0] active_o,
    output logic              cmp_flag_o,
    output logic              cap_flag_o
);
    ch_mode_e          mode_q;
    logic              pe_q;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] preload_q;
    logic [DATA_W-1:0] active_q;
    logic              cmp_q;
    logic              cap_q;
    logic              cap_evt;
    logic              wr_val_cmp;
    logic [DATA_W-1:0] rd_mux;

    // Capture only counts in input mode; value writes only in output mode
    assign cap_evt    = rise_i && (mode_q == MODE_CAPTURE);
    assign wr_val_cmp = wr_en_i && (addr_i == ADR_VAL) && (mode_q == MODE_COMPARE);

    // Control and selector registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_COMPARE;
            pe_q   <= 1'b0;
            sel_q  <= '0;
        end else if (wr_en_i) begin
            if (addr_i == ADR_CTRL) begin
                mode_q <= ch_mode_e'(wr_data_i[CTRL_MODE_BIT]);
                pe_q   <= wr_data_i[CTRL_PE_BIT];
            end
            if (addr_i == ADR_SEL) sel_q <= wr_data_i[SEL_W-1:0];
        end
    end

    // Preload register: loaded by value writes in output mode
    always_ff @(posedge clk) begin
        if (!rst_n)          preload_q <= '0;
        else if (wr_val_cmp) preload_q <= wr_data_i;
    end

    // Active register: capture, direct load, or update-event transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (cap_evt) begin
            active_q <= cnt_i;
        end else if (mode_q == MODE_COMPARE) begin
            if (wr_val_cmp && !pe_q) active_q <= wr_data_i;
            else if (pe_q && upd_i)  active_q <= preload_q;
        end
    end

    // Sticky flags, write-one-to-clear, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= 1'b0;
            cap_q <= 1'b0;
        end else begin
            if (match_i)
                cmp_q <= 1'b1;
            else if (wr_en_i && addr_i == ADR_FLAG && wr_data_i[FLAG_CMP_BIT])
                cmp_q <= 1'b0;
            if (cap_evt)
                cap_q <= 1'b1;
            else if (wr_en_i && addr_i == ADR_FLAG && wr_data_i[FLAG_CAP_BIT])
                cap_q <= 1'b0;
        end
    end

    // Read multiplexer with capture bypass on the value address
    always_comb begin
        rd_mux = '0;
        case (addr_i)
            ADR_CTRL: begin
                rd_mux[CTRL_MODE_BIT] = mode_q;
                rd_mux[CTRL_PE_BIT]   = pe_q;
            end
            ADR_VAL: begin
                if (mode_q == MODE_CAPTURE) rd_mux = cap_evt ? cnt_i : active_q;
                else                        rd_mux = preload_q;
            end
            ADR_SEL:  rd_mux[SEL_W-1:0] = sel_q;
            default: begin
                rd_mux[FLAG_CMP_BIT] = cmp_q;
                rd_mux[FLAG_CAP_BIT] = cap_q;
            end
        endcase
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data_o <= '0;
        else if (rd_en_i) rd_data_o <= rd_mux;
    end

    assign mode_o     = mode_q;
    assign pe_o       = pe_q;
    assign sel_o      = sel_q;
    assign preload_o  = preload_q;
    assign active_o   = active_q;
    assign cmp_flag_o = cmp_q;
    assign cap_flag_o = cap_q;
endmodule

// File: rtl/ccp_channel.sv
// Module: ccp_channel (top)
// One capture/compare channel with preloaded compare value and a selectable
// capture source. Assumes cnt_i and upd_i come from the counter in clk domain.
module ccp_channel
    import ccp_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int N_SRC       = 5,
    parameter int SEL_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cnt_i,
    input  logic              upd_i,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              ch_out_o,
    output logic              cmp_flag_o,
    output logic              cap_flag_o
);
    logic              mode_w;
    logic              pe_w;
    logic [SEL_W-1:0]  sel_w;
    logic [DATA_W-1:0] preload_w;
    logic [DATA_W-1:0] active_w;
    logic              rise_w;
    logic              match_w;

    ccp_capture #(
        .N_SRC(N_SRC), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_cap (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .sel_i(sel_w), .rise_o(rise_w)
    );

    ccp_compare #(.DATA_W(DATA_W)) u_cmp (
        .capture_mode_i(mode_w), .cnt_i(cnt_i), .active_i(active_w), .match_o(match_w)
    );

    ccp_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .upd_i(upd_i),
        .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .wr_data_i(wr_data_i),
        .rise_i(rise_w), .match_i(match_w), .rd_data_o(rd_data_o),
        .mode_o(mode_w), .pe_o(pe_w), .sel_o(sel_w), .preload_o(preload_w),
        .active_o(active_w), .cmp_flag_o(cmp_flag_o), .cap_flag_o(cap_flag_o)
    );

    // Output pin follows the compare match
    assign ch_out_o = match_w;
endmodule

// File: rtl/ccp_channel_chk.sv
// Module: ccp_channel_chk
// Protocol checker for ccp_channel, attached by bind. Assumes default widths.
module ccp_channel_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_i,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [1:0]        addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              ch_out_o,
    input logic              cmp_flag_o,
    input logic              mode_w,
    input logic              pe_w,
    input logic [DATA_W-1:0] preload_w,
    input logic [DATA_W-1:0] active_w
);
    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_w && !pe_w && wr_en_i && addr_i == 2'd1) |=> active_w == $past(wr_data_i)); // R2
    AST_HOLD_UNTIL_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_w && pe_w && !upd_i) |=> $stable(active_w)); // R3
    AST_SILENT_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_w |-> !ch_out_o); // R4
    AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ch_out_o |=> cmp_flag_o); // R5
    AST_SEL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == 2'd2) |=> rd_data_o[DATA_W-1:4] == '0); // R8
    AST_CAPTURE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w && wr_en_i && addr_i == 2'd1) |=> $stable(preload_w)); // R9
endmodule

bind ccp_channel ccp_channel_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .ch_out_o(ch_out_o), .cmp_flag_o(cmp_flag_o), .mode_w(mode_w), .pe_w(pe_w),
    .preload_w(preload_w), .active_w(active_w)
);

// File: tb/tb_ccp_channel.sv
// Bench for ccp_channel: a compare vector table, then directed capture tests.
module tb_ccp_channel;
    localparam int CLK_PERIOD = 10;
    localparam int N_ROWS     = 7;

    // Row: preload enable, written value, pulse update, counter, expected pin
    typedef struct packed {
        logic        pe;
        logic [15:0] wval;
        logic        upd;
        logic [15:0] cnt;
        logic        exp_out;
    } row_t;

    localparam row_t VEC [N_ROWS] = '{
        '{1'b0, 16'h0010, 1'b0, 16'h0010, 1'b1},
        '{1'b1, 16'h0020, 1'b0, 16'h0020, 1'b0},
        '{1'b1, 16'h0020, 1'b0, 16'h0010, 1'b1},
        '{1'b1, 16'h0030, 1'b1, 16'h0030, 1'b1},
        '{1'b1, 16'h0040, 1'b1, 16'h0030, 1'b0},
        '{1'b0, 16'hFFFF, 1'b0, 16'hFFFF, 1'b1},
        '{1'b0, 16'h0000, 1'b1, 16'h0000, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_i = 16'h1234;
    logic        upd_i = 1'b0;
    logic [4:0]  src_i = '0;
    logic        wr_en_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [1:0]  addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] rd_data_o;
    logic        ch_out_o, cmp_flag_o, cap_flag_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] rv;

    ccp_channel dut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .upd_i(upd_i), .src_i(src_i),
        .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .wr_data_i(wr_data_i),
        .rd_data_o(rd_data_o), .ch_out_o(ch_out_o), .cmp_flag_o(cmp_flag_o),
        .cap_flag_o(cap_flag_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
        @(negedge clk); wr_en_i = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); rd_en_i = 1'b1; addr_i = a;
        @(negedge clk); rd_en_i = 1'b0; d = rd_data_o;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hang counts as a failure and still prints the summary
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        // R1: reset values
        bus_rd(2'd0, rv); check("R1 ctrl", rv, 16'h0000);
        bus_rd(2'd1, rv); check("R1 value", rv, 16'h0000);
        bus_rd(2'd2, rv); check("R1 sel", rv, 16'h0000);
        bus_rd(2'd3, rv); check("R1 flags", rv, 16'h0000);
        check("R1 pin", {15'd0, ch_out_o}, 16'd0);

        // R2 R3 R4: compare table
        for (int i = 0; i < N_ROWS; i++) begin
            bus_wr(2'd0, {14'd0, VEC[i].pe, 1'b0});
            bus_wr(2'd1, VEC[i].wval);
            if (VEC[i].upd) begin
                @(negedge clk); upd_i = 1'b1;
                @(negedge clk); upd_i = 1'b0;
            end
            @(negedge clk); cnt_i = VEC[i].cnt;
            #1 check($sformatf("R2/R3/R4 row %0d", i), {15'd0, ch_out_o}, {15'd0, VEC[i].exp_out});
        end

        // R5: compare flag sticky and cleared by writing one
        bus_wr(2'd1, 16'h0100);
        cnt_i = 16'h0000;
        bus_wr(2'd3, 16'h0003);
        bus_rd(2'd3, rv); check("R5 cleared", rv & 16'h1, 16'h0);
        @(negedge clk); cnt_i = 16'h0100;
        @(negedge clk); cnt_i = 16'h0000;
        wait_cyc(2);
        bus_rd(2'd3, rv); check("R5 sticky", rv & 16'h1, 16'h1);
        bus_wr(2'd3, 16'h0001);
        bus_rd(2'd3, rv); check("R5 w1c", rv & 16'h1, 16'h0);

        // R6 R11: capture from the pin, code 0
        bus_wr(2'd0, 16'h0001);
        cnt_i = 16'h1234;
        wait_cyc(3);
        bus_wr(2'd3, 16'h0003);
        @(negedge clk); src_i[0] = 1'b1;
        wait_cyc(4);
        bus_rd(2'd1, rv); check("R6 pin capture", rv, 16'h1234);
        check("R11 flag port", {15'd0, cap_flag_o}, 16'd1);
        bus_rd(2'd3, rv); check("R11 flag set", rv & 16'h2, 16'h2);
        bus_wr(2'd3, 16'h0002);
        bus_rd(2'd3, rv); check("R11 flag cleared", rv & 16'h2, 16'h0);
        src_i[0] = 1'b0;

        // R7: alternate source code 3, then unselected pin toggles
        bus_wr(2'd2, 16'h0003);
        wait_cyc(4);
        cnt_i = 16'h0ABC;
        @(negedge clk); src_i[3] = 1'b1;
        wait_cyc(4);
        bus_rd(2'd1, rv); check("R7 code 3 capture", rv, 16'h0ABC);
        cnt_i = 16'h0DEF;
        @(negedge clk); src_i[0] = 1'b1;
        wait_cyc(4);
        bus_rd(2'd1, rv); check("R7 unselected ignored", rv, 16'h0ABC);

        // R8 R7: upper selector bits read zero; reserved code never captures
        bus_wr(2'd2, 16'hFFFF);
        bus_rd(2'd2, rv); check("R8 sel readback", rv, 16'h000F);
        src_i = '0;
        wait_cyc(4);
        bus_wr(2'd3, 16'h0003);
        @(negedge clk); src_i = 5'h1F;
        wait_cyc(5);
        bus_rd(2'd3, rv); check("R7 reserved no flag", rv & 16'h2, 16'h0);
        bus_rd(2'd1, rv); check("R7 reserved no capture", rv, 16'h0ABC);

        // R9: writes ignored in input mode; output-mode preload unchanged
        bus_wr(2'd1, 16'h5555);
        bus_rd(2'd1, rv); check("R9 active kept", rv, 16'h0ABC);
        // R4: pin low in input mode even when counter equals active
        cnt_i = 16'h0ABC;
        #1 check("R4 input mode pin", {15'd0, ch_out_o}, 16'd0);
        bus_wr(2'd0, 16'h0000);
        bus_rd(2'd1, rv); check("R9 preload kept", rv, 16'h0100);
        bus_wr(2'd0, 16'h0001);

        // R10: read coinciding with capture returns new count
        src_i = '0;
        bus_wr(2'd2, 16'h0000);
        wait_cyc(4);
        cnt_i = 16'h7777;
        @(negedge clk); src_i[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); rd_en_i = 1'b1; addr_i = 2'd1;
        @(negedge clk); rd_en_i = 1'b0;
        check("R10 bypass", rd_data_o, 16'h7777);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule